// File: doc/BRIEF.md
# Masked Vector Load/Store Engine

This block carries out one masked vector load or store at a time over a simple memory port. Each port word is 64 bits and carries byte enables. A caller pulses a start request together with a byte base address, a 256-bit mask vector, a direction flag and two configuration bits. For stores the caller also supplies a 256-bit data vector. The configuration bits pick 32-bit or 64-bit elements and a 128-bit or 256-bit vector length. The sign bit of each mask element decides whether that element takes part.

The engine walks the enabled elements one at a time. It makes exactly one memory access per enabled element and leaves disabled elements alone. A load builds its result in a 256-bit register, with zeros in every element that did not take part. A store writes only the bytes of enabled elements. When the walk is over, a one-cycle done pulse marks the end. A fault reported by memory, or a base address that does not match the element size, ends the operation early, and the done pulse then carries a fault flag and the index of the element at fault.

Top module: `masked_vec_mover`

## Requirements
- R1: An element is enabled exactly when the top bit of its slice of `maskVec` is 1. For a 32-bit element i that is bit 32*i+31, and for a 64-bit element i it is bit 64*i+63. All other mask bits have no effect.
- R2: A load of an enabled element i reads the byte address base + i*S, where S is 4 or 8. That address goes out on `memAddr` as address>>3. A 32-bit element at a byte address with bit 2 set comes from `memRdata[63:32]`, otherwise from `memRdata[31:0]`. It lands in result element i.
- R3: A load sets every disabled element of `loadResult` to zero. With the 128-bit length, bits 255:128 are zero as well.
- R4: A store writes the enabled elements of `storeVec` to their addresses. A 64-bit element uses byte enable 0xFF. A 32-bit element uses 0x0F in the low half of the word and 0xF0 in the high half. No other byte of memory changes, and `memRead` and `memWrite` are never high together.
- R5: No access is made for a disabled element. An all-zero mask finishes with no access at all and no fault, even if the memory would fault.
- R6: Enabled elements are accessed in ascending index order, and each access completes on a cycle where `memReady` is high. While `memReady` is low, the pending access holds steady. With `memReady` always high, one element completes per cycle.
- R7: If `memFault` is high together with `memReady` on an access, the operation ends. No later element is accessed, and the done pulse comes with `faultOut`=1 and `faultIndex` equal to that element's index.
- R8: A base address that is not a multiple of the element size produces `faultOut` with `faultIndex`=0 and no access, whatever the mask holds.
- R9: `donePulse` is high for exactly one cycle. It comes k+1 cycles after the start edge when k accesses complete without a stall. `busy` is high from the cycle after start through the done cycle, and a start request is ignored while `busy` is high.
- R10: The element count is 4 or 8 for 32-bit elements and 2 or 4 for 64-bit elements, for the 128-bit or 256-bit length. Mask bits of elements beyond that count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, taken when not busy |
| isStore | input | 1 | 1 = store, 0 = load |
| elemIs64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit |
| vecIs256 | input | 1 | 1 = 256-bit length, 0 = 128-bit |
| baseAddr | input | 32 | Byte base address |
| maskVec | input | 256 | Mask vector; element sign bits enable |
| storeVec | input | 256 | Store data vector |
| memAddr | output | 29 | Memory word address |
| memRead | output | 1 | Read request |
| memWrite | output | 1 | Write request |
| memByteEn | output | 8 | Byte enables of a write |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| memFault | input | 1 | Access faults, sampled with memReady |
| loadResult | output | 256 | Load result vector |
| donePulse | output | 1 | One-cycle completion pulse |
| faultOut | output | 1 | Fault flag, valid with donePulse |
| faultIndex | output | 3 | Index of the faulting element |
| busy | output | 1 | Operation in progress |

## Verification
Directed loads and stores cover every combination of element size and vector length. Full masks show the address order and timing. Single-element masks, and masks with ones only in the low bits of each element, separate sign-bit enabling from any-bit enabling. Masks with bits set beyond the vector length show that the length limit is applied. Stores with alternating masks check that a 32-bit write leaves the other half of its memory word intact. Fault cases place the failing word in the middle of a walk, behind an all-zero mask, and under a misaligned base. A run with memory stalled while a second start arrives shows that the request is ignored. Randomized operations with random ready stalls are then compared against a memory shadow and a result computed in the bench.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  localparam int MVM_VEC_W    = 256;
  localparam int MVM_WORD_W   = 64;
  localparam int MVM_NARROW_W = 32;
  localparam int MVM_IDX_W    = $clog2(MVM_VEC_W / MVM_NARROW_W);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mvmState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic                 loadInit;  // operation accepted: latch operands
    logic                 issue;     // an access is on the port
    logic                 capture;   // load element completes this cycle
    logic                 finish;    // done cycle
    logic [MVM_IDX_W-1:0] elemIdx;   // element being accessed
  } mvmStrobes_t;
endpackage

// File: rtl/mvm_ctrl.sv
module mvm_ctrl
  import mvm_pkg::*;
#(
  parameter int VEC_W    = MVM_VEC_W,
  parameter int NARROW_W = MVM_NARROW_W,
  parameter int WIDE_W   = MVM_WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startReq,
  input  logic                 isStore,
  input  logic                 elemIs64,
  input  logic                 vecIs256,
  input  logic [VEC_W-1:0]     maskVec,
  input  logic                 misalign,
  input  logic                 memReady,
  input  logic                 memFault,
  output logic                 memRead,
  output logic                 memWrite,
  output logic                 donePulse,
  output logic                 faultOut,
  output logic [MVM_IDX_W-1:0] faultIndex,
  output logic                 busy,
  output mvmStrobes_t          strobes
);
  localparam int MAX_ELEM  = VEC_W / NARROW_W;
  localparam int WIDE_ELEM = VEC_W / WIDE_W;
  localparam int IDX_W     = MVM_IDX_W;

  mvmState_t            state;
  logic [MAX_ELEM-1:0]  pending;
  logic [MAX_ELEM-1:0]  enabledReg;
  logic                 faultFlag;
  logic [IDX_W-1:0]     faultIdxReg;
  logic                 storeReg;

  logic [MAX_ELEM-1:0]  narrowEn;
  logic [MAX_ELEM-1:0]  wideEn;
  logic [MAX_ELEM-1:0]  lenMask;
  logic [MAX_ELEM-1:0]  enNow;
  logic [IDX_W-1:0]     curIdx;
  logic                 hasPending;
  logic                 issue;
  logic                 accept;

  // Per-element enable taken from the sign bit of each mask element
  for (genvar g = 0; g < MAX_ELEM; g++) begin : g_narrow
    assign narrowEn[g] = maskVec[g*NARROW_W + NARROW_W - 1];
  end
  for (genvar g = 0; g < MAX_ELEM; g++) begin : g_wide
    if (g < WIDE_ELEM) begin : g_on
      assign wideEn[g] = maskVec[g*WIDE_W + WIDE_W - 1];
    end else begin : g_off
      assign wideEn[g] = 1'b0;
    end
  end

  // Element count limit from size and length
  always_comb begin
    int count;
    count = (elemIs64 ? WIDE_ELEM : MAX_ELEM) >> (vecIs256 ? 0 : 1);
    for (int i = 0; i < MAX_ELEM; i++) lenMask[i] = (i < count);
  end

  assign enNow = (elemIs64 ? wideEn : narrowEn) & lenMask;

  // Lowest pending index wins
  always_comb begin
    curIdx = '0;
    for (int i = MAX_ELEM - 1; i >= 0; i--) begin
      if (pending[i]) curIdx = IDX_W'(i);
    end
  end

  assign hasPending = |pending;
  assign accept     = startReq && (state == ST_IDLE);
  assign issue      = (state == ST_RUN) && hasPending;
  assign memRead    = issue && !storeReg;
  assign memWrite   = issue && storeReg;
  assign donePulse  = (state == ST_RUN) && !hasPending;
  assign faultOut   = donePulse && faultFlag;
  assign faultIndex = faultIdxReg;
  assign busy       = (state == ST_RUN);

  assign strobes.loadInit = accept;
  assign strobes.issue    = issue;
  assign strobes.capture  = issue && memReady && !memFault && !storeReg;
  assign strobes.finish   = donePulse;
  assign strobes.elemIdx  = curIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pending     <= '0;
      enabledReg  <= '0;
      faultFlag   <= 1'b0;
      faultIdxReg <= '0;
      storeReg    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state       <= ST_RUN;
            storeReg    <= isStore;
            pending     <= misalign ? '0 : enNow;
            enabledReg  <= misalign ? '0 : enNow;
            faultFlag   <= misalign;
            faultIdxReg <= '0;
          end
        end
        default: begin
          if (!hasPending) begin
            state <= ST_IDLE;
          end else if (memReady) begin
            if (memFault) begin
              pending     <= '0;
              faultFlag   <= 1'b1;
              faultIdxReg <= curIdx;
            end else begin
              pending[curIdx] <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  // R5: accesses only for elements enabled at acceptance
  assert_only_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> enabledReg[curIdx]);

  // R4: never read and write together
  assert_rw_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRead && memWrite));

  // R6: next access has a higher index
  assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && memReady && !memFault) |=> (!issue || (curIdx > $past(curIdx))));

  // R6: a stalled access holds
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !memReady) |=> (issue && curIdx == $past(curIdx) && $stable(memWrite)));

  // R9: done lasts one cycle
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse);

  // R7: a faulting access ends the walk
  assert_fault_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && memReady && memFault) |=> (donePulse && faultOut && faultIndex == $past(curIdx)));

  // R8: misaligned base faults at once with no access
  assert_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misalign) |=> (donePulse && faultOut && !issue && faultIndex == '0));
endmodule

// File: rtl/mvm_datapath.sv
module mvm_datapath
  import mvm_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int VEC_W    = MVM_VEC_W,
  parameter int WORD_W   = MVM_WORD_W,
  parameter int NARROW_W = MVM_NARROW_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  mvmStrobes_t                   strobes,
  input  logic [ADDR_W-1:0]             baseAddr,
  input  logic [VEC_W-1:0]              storeVec,
  input  logic                          elemIs64,
  input  logic                          vecIs256,
  output logic                          misalign,
  output logic [ADDR_W-$clog2(WORD_W/8)-1:0] memAddr,
  output logic [WORD_W/8-1:0]           memByteEn,
  output logic [WORD_W-1:0]             memWdata,
  input  logic [WORD_W-1:0]             memRdata,
  output logic [VEC_W-1:0]              loadResult
);
  localparam int WORD_B   = WORD_W / 8;
  localparam int NARROW_B = NARROW_W / 8;
  localparam int WORD_SH  = $clog2(WORD_B);
  localparam int NARROW_SH = $clog2(NARROW_B);
  localparam int LANES    = WORD_W / NARROW_W;
  localparam int LANE_W   = WORD_SH - NARROW_SH;

  logic [ADDR_W-1:0]  baseReg;
  logic [VEC_W-1:0]   storeReg;
  logic [VEC_W-1:0]   resultReg;
  logic               is64Reg;
  logic               vec256Reg;

  logic [ADDR_W-1:0]  elemAddr;
  logic [LANE_W-1:0]  lane;
  logic [NARROW_W-1:0] narrowWord;
  logic [WORD_W-1:0]  wideWord;
  logic [NARROW_W-1:0] rdNarrow;

  assign misalign = elemIs64 ? (|baseAddr[WORD_SH-1:0]) : (|baseAddr[NARROW_SH-1:0]);

  assign elemAddr = baseReg + (is64Reg ? (ADDR_W'(strobes.elemIdx) << WORD_SH)
                                       : (ADDR_W'(strobes.elemIdx) << NARROW_SH));
  assign lane     = elemAddr[WORD_SH-1:NARROW_SH];
  assign memAddr  = elemAddr[ADDR_W-1:WORD_SH];

  assign narrowWord = NARROW_W'(storeReg >> (int'(strobes.elemIdx) * NARROW_W));
  assign wideWord   = WORD_W'(storeReg >> (int'(strobes.elemIdx) * WORD_W));
  assign memWdata   = is64Reg ? wideWord : {LANES{narrowWord}};
  assign memByteEn  = is64Reg ? {WORD_B{1'b1}}
                              : (WORD_B'({NARROW_B{1'b1}}) << (int'(lane) * NARROW_B));

  assign rdNarrow   = NARROW_W'(memRdata >> (int'(lane) * NARROW_W));
  assign loadResult = resultReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg   <= '0;
      storeReg  <= '0;
      resultReg <= '0;
      is64Reg   <= 1'b0;
      vec256Reg <= 1'b0;
    end else if (strobes.loadInit) begin
      baseReg   <= baseAddr;
      storeReg  <= storeVec;
      is64Reg   <= elemIs64;
      vec256Reg <= vecIs256;
      resultReg <= '0;
    end else if (strobes.capture) begin
      if (is64Reg) resultReg[int'(strobes.elemIdx)*WORD_W +: WORD_W] <= memRdata;
      else         resultReg[int'(strobes.elemIdx)*NARROW_W +: NARROW_W] <= rdNarrow;
    end
  end

  // R3: short vectors leave the upper half clear
  assert_upper_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.finish && !vec256Reg) |-> (resultReg[VEC_W-1:VEC_W/2] == '0));

  // R4: a narrow access enables exactly one lane
  assert_lane_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.issue && !is64Reg) |-> ($countones(memByteEn) == NARROW_B));
endmodule

// File: rtl/masked_vec_mover.sv
module masked_vec_mover
  import mvm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 startReq,
  input  logic                 isStore,
  input  logic                 elemIs64,
  input  logic                 vecIs256,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [MVM_VEC_W-1:0] maskVec,
  input  logic [MVM_VEC_W-1:0] storeVec,
  output logic [ADDR_W-$clog2(MVM_WORD_W/8)-1:0] memAddr,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [MVM_WORD_W/8-1:0] memByteEn,
  output logic [MVM_WORD_W-1:0] memWdata,
  input  logic [MVM_WORD_W-1:0] memRdata,
  input  logic                 memReady,
  input  logic                 memFault,
  output logic [MVM_VEC_W-1:0] loadResult,
  output logic                 donePulse,
  output logic                 faultOut,
  output logic [MVM_IDX_W-1:0] faultIndex,
  output logic                 busy
);
  mvmStrobes_t strobes;
  logic        misalign;

  mvm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startReq   (startReq),
    .isStore    (isStore),
    .elemIs64   (elemIs64),
    .vecIs256   (vecIs256),
    .maskVec    (maskVec),
    .misalign   (misalign),
    .memReady   (memReady),
    .memFault   (memFault),
    .memRead    (memRead),
    .memWrite   (memWrite),
    .donePulse  (donePulse),
    .faultOut   (faultOut),
    .faultIndex (faultIndex),
    .busy       (busy),
    .strobes    (strobes)
  );

  mvm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .baseAddr   (baseAddr),
    .storeVec   (storeVec),
    .elemIs64   (elemIs64),
    .vecIs256   (vecIs256),
    .misalign   (misalign),
    .memAddr    (memAddr),
    .memByteEn  (memByteEn),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .loadResult (loadResult)
  );
endmodule

// File: tb/masked_vec_mover_test.sv
module masked_vec_mover_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         startReq = 1'b0;
  logic         isStore = 1'b0;
  logic         elemIs64 = 1'b0;
  logic         vecIs256 = 1'b0;
  logic [31:0]  baseAddr = '0;
  logic [255:0] maskVec = '0;
  logic [255:0] storeVec = '0;
  logic [28:0]  memAddr;
  logic         memRead, memWrite;
  logic [7:0]   memByteEn;
  logic [63:0]  memWdata;
  logic [63:0]  memRdata;
  logic         memReady = 1'b1;
  logic         memFault;
  logic [255:0] loadResult;
  logic         donePulse, faultOut, busy;
  logic [2:0]   faultIndex;

  int checks = 0;
  int fails  = 0;
  int readyMode = 1;         // 0 random, 1 always high, 2 held low
  logic        faultEn = 1'b0;
  logic [28:0] faultWord = '0;

  logic [63:0] memArr [MEM_WORDS];
  logic [63:0] shadow [MEM_WORDS];
  logic [28:0] logAddr [1024];
  int logCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  masked_vec_mover uut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .isStore(isStore),
    .elemIs64(elemIs64), .vecIs256(vecIs256), .baseAddr(baseAddr),
    .maskVec(maskVec), .storeVec(storeVec), .memAddr(memAddr),
    .memRead(memRead), .memWrite(memWrite), .memByteEn(memByteEn),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .memFault(memFault), .loadResult(loadResult), .donePulse(donePulse),
    .faultOut(faultOut), .faultIndex(faultIndex), .busy(busy)
  );

  function automatic logic [63:0] initWord(int w);
    return {32'hD00D0000 | 32'(w), 32'h0BAD0000 | 32'(w * 7)};
  endfunction

  // Memory model: combinational read, write on a ready edge
  assign memRdata = memArr[memAddr[5:0]];
  assign memFault = faultEn && (memAddr == faultWord);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < MEM_WORDS; w++) memArr[w] <= initWord(w);
    end else if ((memRead || memWrite) && memReady) begin
      if (logCnt < 1024) logAddr[logCnt] <= memAddr;
      logCnt <= logCnt + 1;
      if (memWrite && !memFault)
        for (int b = 0; b < 8; b++)
          if (memByteEn[b]) memArr[memAddr[5:0]][b*8 +: 8] <= memWdata[b*8 +: 8];
    end
  end

  always @(negedge clk) begin
    case (readyMode)
      0:       memReady = ($urandom % 4) != 0;
      1:       memReady = 1'b1;
      default: memReady = 1'b0;
    endcase
  end

  task automatic chk(input string req, input string what,
                     input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic runOp(input bit st, input bit e64, input bit v256,
                       input logic [31:0] base, input logic [255:0] mask,
                       input logic [255:0] data, input bit fEn,
                       input logic [28:0] fWord, input int rmode,
                       input bit poke, input string req);
    int esz, n, nAcc, cyc, startCnt, mism;
    bit expFault;
    logic [2:0] expFidx;
    logic [255:0] expRes;
    logic [28:0] expAddr [8];
    esz = e64 ? 8 : 4;
    n = (v256 ? 256 : 128) / (esz * 8);
    nAcc = 0; expFault = 0; expFidx = '0; expRes = '0;
    if ((base % esz) != 0) begin
      expFault = 1;
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] a;
        logic [28:0] w;
        if (!expFault && mask[i*esz*8 + esz*8 - 1]) begin
          a = base + 32'(i * esz);
          w = a[31:3];
          expAddr[nAcc] = w;
          nAcc++;
          if (fEn && w == fWord) begin
            expFault = 1;
            expFidx = 3'(i);
          end else if (st) begin
            if (e64) shadow[w[5:0]] = data[i*64 +: 64];
            else shadow[w[5:0]][int'(a[2])*32 +: 32] = data[i*32 +: 32];
          end else begin
            if (e64) expRes[i*64 +: 64] = shadow[w[5:0]];
            else expRes[i*32 +: 32] = shadow[w[5:0]][int'(a[2])*32 +: 32];
          end
        end
      end
    end

    @(negedge clk);
    readyMode = poke ? 2 : rmode;
    faultEn = fEn; faultWord = fWord;
    isStore = st; elemIs64 = e64; vecIs256 = v256;
    baseAddr = base; maskVec = mask; storeVec = data;
    startCnt = logCnt;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    cyc = 1;
    if (poke) chk("R9", "busy after start", 256'(busy), 256'(1));
    while (!donePulse && cyc < 300) begin
      if (poke && cyc == 2) begin
        startReq = 1'b1; isStore = ~st; maskVec = '1; baseAddr = '0;
      end else begin
        startReq = 1'b0;
      end
      if (poke && cyc == 5) readyMode = 1;
      @(negedge clk);
      cyc++;
    end
    startReq = 1'b0;
    chk(req, "done seen", 256'(donePulse), 256'(1));
    chk(expFault ? (base % esz != 0 ? "R8" : "R7") : req, "fault flag",
        256'(faultOut), 256'(expFault));
    if (expFault) chk((base % esz != 0) ? "R8" : "R7", "fault index",
                      256'(faultIndex), 256'(expFidx));
    chk("R5", "access count", 256'(logCnt - startCnt), 256'(nAcc));
    for (int j = 0; j < nAcc; j++)
      if (j < logCnt - startCnt)
        chk("R6", "access address order", 256'(logAddr[startCnt + j]), 256'(expAddr[j]));
    if (rmode == 1 && !poke) chk("R9", "done latency", 256'(cyc), 256'(nAcc + 1));
    if (!st && !expFault) chk(req, "load result", loadResult, expRes);
    @(negedge clk);
    chk("R9", "done single pulse", 256'(donePulse), 256'(0));
    chk("R9", "busy cleared", 256'(busy), 256'(0));
    mism = 0;
    for (int w = 0; w < MEM_WORDS; w++) if (memArr[w] !== shadow[w]) mism++;
    chk("R4", "memory words differing from shadow", 256'(mism), 256'(0));
    faultEn = 1'b0;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R9 watchdog got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [255:0] d, m;
    void'($urandom(32'd2718));
    for (int w = 0; w < MEM_WORDS; w++) shadow[w] = initWord(w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset busy", 256'(busy), 256'(0));
    chk("R9", "reset done", 256'(donePulse), 256'(0));
    chk("R5", "reset no access", 256'({memRead, memWrite}), 256'(0));
    chk("R3", "reset result", loadResult, '0);

    d = rnd256();
    // R2 R1: full dword load, 256-bit, ready high
    m = '0; for (int i = 0; i < 8; i++) m[i*32+31] = 1'b1;
    runOp(0, 0, 1, 32'd64, m, d, 0, '0, 1, 0, "R2");
    // R2: dword load at odd dword base
    runOp(0, 0, 1, 32'd100, m, d, 0, '0, 1, 0, "R2");
    // R3: 128-bit qword load with only element 1
    m = '0; m[127] = 1'b1;
    runOp(0, 1, 0, 32'd200, m, d, 0, '0, 1, 0, "R3");
    // R10: 128-bit dword load, mask set on elements 0 and 4..7
    m = '0; m[31] = 1'b1; for (int i = 4; i < 8; i++) m[i*32+31] = 1'b1;
    runOp(0, 0, 0, 32'd8, m, d, 0, '0, 1, 0, "R10");
    // R10: 128-bit qword store, mask also on elements 2,3
    m = '0; for (int i = 0; i < 4; i++) m[i*64+63] = 1'b1;
    runOp(1, 1, 0, 32'd320, m, d, 0, '0, 1, 0, "R10");
    // R4: qword store, alternating mask
    m = '0; m[63] = 1'b1; m[191] = 1'b1;
    runOp(1, 1, 1, 32'd400, m, rnd256(), 0, '0, 1, 0, "R4");
    // R4: dword store, odd elements only (high lanes)
    m = '0; for (int i = 1; i < 8; i += 2) m[i*32+31] = 1'b1;
    runOp(1, 0, 1, 32'd16, m, rnd256(), 0, '0, 1, 0, "R4");
    // R4: dword store, even elements only (low lanes)
    m = '0; for (int i = 0; i < 8; i += 2) m[i*32+31] = 1'b1;
    runOp(1, 0, 1, 32'd48, m, rnd256(), 0, '0, 1, 0, "R4");
    // R5: all-zero mask, memory would fault at base
    runOp(0, 0, 1, 32'd128, '0, d, 1, 29'd16, 1, 0, "R5");
    // R1: every bit set except element sign bits
    m = '1; for (int i = 0; i < 8; i++) m[i*32+31] = 1'b0;
    runOp(0, 0, 1, 32'd0, m, d, 0, '0, 1, 0, "R1");
    // R1: qword mode ignores dword sign bits in the low halves
    m = '0; for (int i = 0; i < 4; i++) m[i*64+31] = 1'b1;
    runOp(1, 1, 1, 32'd256, m, d, 0, '0, 1, 0, "R1");
    // R7: fault on element 2 of full dword store
    m = '0; for (int i = 0; i < 8; i++) m[i*32+31] = 1'b1;
    runOp(1, 0, 1, 32'd80, m, rnd256(), 1, 29'd11, 1, 0, "R7");
    // R7: fault on qword load element 3
    runOp(0, 1, 1, 32'd160, '1, d, 1, 29'd23, 1, 0, "R7");
    // R8: misaligned dword base with zero mask
    runOp(0, 0, 1, 32'd66, '0, d, 0, '0, 1, 0, "R8");
    // R8: qword base aligned only to 4
    runOp(1, 1, 1, 32'd36, '1, d, 0, '0, 1, 0, "R8");
    // R9: start while busy is ignored, memory stalled
    m = '0; for (int i = 0; i < 4; i++) m[i*64+63] = 1'b1;
    runOp(0, 1, 1, 32'd288, m, d, 0, '0, 1, 1, "R9");
    // R6: random stalls
    runOp(0, 0, 1, 32'd352, '1, d, 0, '0, 0, 0, "R6");

    for (int k = 0; k < 50; k++) begin
      bit st, e64, v;
      int esz, fe;
      logic [31:0] base;
      st = 1'($urandom % 2); e64 = 1'($urandom % 2); v = 1'($urandom % 2);
      esz = e64 ? 8 : 4;
      base = 32'(($urandom % (e64 ? 60 : 120)) * esz);
      if ($urandom % 8 == 0) base = base + 32'(1 + $urandom % (esz - 1));
      fe = ($urandom % 5 == 0) ? 1 : 0;
      runOp(st, e64, v, base, rnd256(), rnd256(), fe[0], 29'((base >> 3) + ($urandom % 4)),
            ($urandom % 2 == 0) ? 0 : 1, 0, st ? "R4" : "R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule